// File: doc/BRIEF.md
# Sound Generator Bus-Control Adapter

This block sits between a CPU bus and an external sound-generator chip that is steered by three bus-control strobes: a direction strobe and two function-select strobes. The CPU sees two locations, picked by address bit 0. Writing to the odd location loads a register index into the sound chip. Reading or writing the even location reads or writes the register that index selects. The two function strobes come straight from CPU read/not-write and address bit 0: the direction strobe is the inverse of read/not-write, the low function strobe is address bit 0 XOR read/not-write, and the high function strobe is tied high. Because of the XOR, the data register answers at the same location for both reads and writes.

Inputs are sampled on the rising clock edge and the strobes come from registers, so the strobes are glitch-free and change one cycle after a CPU access. The block steers both data directions. Write data is driven toward the sound chip only while a write or index-latch code is out. Data is returned to the CPU only while the read code is out. For checking, the block also keeps a shadow of the latched index (4 bits) and of the sixteen register values last written, and shows the entry at the current index.

Top module: `psg_bus_adapter`

## Requirements
- R1: After reset the strobes carry the idle code (direction 0, low function 0, high function 1), neither data direction is enabled, the shadow index is 0 and every shadow entry is 0.
- R2: A selected write to the even location (rnw=0, a0=0) drives direction=1 and low function=0 one cycle later, with the written byte on the sound-chip data output and that output enabled.
- R3: A selected write to the odd location (rnw=0, a0=1) drives direction=1 and low function=1 one cycle later, with the written byte on the sound-chip data output, and it loads the shadow index at the same edge.
- R4: A selected read of the even location (rnw=1, a0=0) drives direction=0 and low function=1 one cycle later, enables the CPU data output, and passes the sound-chip read data to it.
- R5: A selected read of the odd location (rnw=1, a0=1) gives the idle code and enables neither data direction.
- R6: While chip-select (active low) is high, the strobes carry the idle code whatever rnw, a0 and data are, and neither the shadow index nor any shadow entry changes.
- R7: The high function strobe is 1 in every cycle.
- R8: The sound-chip data output enable and the CPU data output enable are never both 1.
- R9: The shadow index keeps only the low 4 bits of the byte latched at the odd location.
- R10: A write to the even location stores the byte in the shadow entry at the current index. The shadow data output always shows the entry at the current shadow index.
- R11: When the CPU data output is not enabled, it reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_cs_n | input | 1 | CPU chip-select, active low |
| cpu_rnw | input | 1 | CPU read (1) / write (0) |
| cpu_a0 | input | 1 | CPU address bit 0 |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Data returned to the CPU |
| cpu_rdata_oe | output | 1 | CPU data output enable |
| psg_bdir | output | 1 | Direction strobe |
| psg_bc2 | output | 1 | High function strobe (tied 1) |
| psg_bc1 | output | 1 | Low function strobe |
| psg_wdata | output | 8 | Data driven to the sound chip |
| psg_wdata_oe | output | 1 | Sound-chip data output enable |
| psg_rdata | input | 8 | Data read back from the sound chip |
| shadow_idx | output | 4 | Shadow of the latched register index |
| shadow_data | output | 8 | Shadow entry at the current index |

## Verification
Each access is applied for one clock cycle. The strobes, the sound-chip data and its enable, the CPU output enable and the shadow index all come from flops loaded at that edge, so they are due exactly one edge later. The CPU read data is a combinational pass-through behind the registered enable, so it is due in that same cycle. The shadow entry is due one edge after its write, or at once after the index moves. The bench drives inputs on the falling edge and samples one nanosecond after the next rising edge, which is the first point where each result is due. It checks the deselected and odd-read cases in that same window, so an effect that should not occur would show up there.

// File: rtl/psg_bc_pkg.sv
package psg_bc_pkg;
  // Bus code as {direction, low function}; high function is always 1.
  typedef enum logic [1:0] {
    BUS_IDLE  = 2'b00,
    BUS_READ  = 2'b01,
    BUS_WRITE = 2'b10,
    BUS_LATCH = 2'b11
  } bus_code_e;
endpackage

// File: rtl/psg_bus_decode.sv
module psg_bus_decode
  import psg_bc_pkg::*;
(
  input  logic      cs_n,
  input  logic      rnw,
  input  logic      a0,
  output bus_code_e code_d
);
  logic dir_raw;
  logic fn_raw;

  always_comb begin
    dir_raw = ~rnw;
    fn_raw  = a0 ^ rnw;
    if (cs_n) code_d = BUS_IDLE;
    else      code_d = bus_code_e'({dir_raw, fn_raw});
  end
endmodule

// File: rtl/psg_ctrl_reg.sv
module psg_ctrl_reg
  import psg_bc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bus_code_e         code_d,
  input  logic [DATA_W-1:0] wdata_d,
  output bus_code_e         code_q,
  output logic [DATA_W-1:0] wdata_q
);
  bus_code_e         code_nxt;
  logic [DATA_W-1:0] wdata_nxt;
  logic              wdata_en;

  always_comb begin
    code_nxt  = code_d;
    wdata_en  = code_d[1];
    wdata_nxt = wdata_en ? wdata_d : wdata_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q  <= BUS_IDLE;
      wdata_q <= '0;
    end else begin
      code_q  <= code_nxt;
      wdata_q <= wdata_nxt;
    end
  end
endmodule

// File: rtl/psg_shadow_file.sv
module psg_shadow_file
  import psg_bc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bus_code_e         code_d,
  input  logic [DATA_W-1:0] wdata_d,
  output logic [IDX_W-1:0]  idx_q,
  output logic [DATA_W-1:0] rd_data
);
  localparam int NREG = 1 << IDX_W;

  logic [IDX_W-1:0]  idx_nxt;
  logic              idx_en;
  logic [DATA_W-1:0] ent_q [NREG];

  always_comb begin
    idx_en  = (code_d == BUS_LATCH);
    idx_nxt = idx_en ? wdata_d[IDX_W-1:0] : idx_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else        idx_q <= idx_nxt;
  end

  for (genvar g = 0; g < NREG; g++) begin : g_ent
    logic              we;
    logic [DATA_W-1:0] nxt;
    always_comb begin
      we  = (code_d == BUS_WRITE) && (idx_q == IDX_W'(g));
      nxt = we ? wdata_d : ent_q[g];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ent_q[g] <= '0;
      else        ent_q[g] <= nxt;
    end
  end

  assign rd_data = ent_q[idx_q];
endmodule

// File: rtl/psg_bus_adapter.sv
module psg_bus_adapter
  import psg_bc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_cs_n,
  input  logic              cpu_rnw,
  input  logic              cpu_a0,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_rdata_oe,
  output logic              psg_bdir,
  output logic              psg_bc2,
  output logic              psg_bc1,
  output logic [DATA_W-1:0] psg_wdata,
  output logic              psg_wdata_oe,
  input  logic [DATA_W-1:0] psg_rdata,
  output logic [IDX_W-1:0]  shadow_idx,
  output logic [DATA_W-1:0] shadow_data
);
  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_sync_q;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s_n = rst_sync_q[1];

  bus_code_e code_d;
  bus_code_e code_q;

  psg_bus_decode u_dec (
    .cs_n   (cpu_cs_n),
    .rnw    (cpu_rnw),
    .a0     (cpu_a0),
    .code_d (code_d)
  );

  psg_ctrl_reg #(.DATA_W(DATA_W)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .code_d  (code_d),
    .wdata_d (cpu_wdata),
    .code_q  (code_q),
    .wdata_q (psg_wdata)
  );

  psg_shadow_file #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_shadow (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .code_d  (code_d),
    .wdata_d (cpu_wdata),
    .idx_q   (shadow_idx),
    .rd_data (shadow_data)
  );

  always_comb begin
    psg_bdir     = code_q[1];
    psg_bc1      = code_q[0];
    psg_bc2      = 1'b1;
    psg_wdata_oe = code_q[1];
    cpu_rdata_oe = (code_q == BUS_READ);
    cpu_rdata    = cpu_rdata_oe ? psg_rdata : '0;
  end
endmodule

// File: rtl/psg_bus_adapter_chk.sv
module psg_bus_adapter_chk #(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_cs_n,
  input logic              cpu_rnw,
  input logic              cpu_a0,
  input logic [DATA_W-1:0] cpu_wdata,
  input logic              cpu_rdata_oe,
  input logic              psg_bdir,
  input logic              psg_bc2,
  input logic              psg_bc1,
  input logic [DATA_W-1:0] psg_wdata,
  input logic              psg_wdata_oe,
  input logic [IDX_W-1:0]  shadow_idx
);
  a_r2_write_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_cs_n && !cpu_rnw && !cpu_a0) |=>
      (psg_bdir && !psg_bc1 && psg_wdata_oe && psg_wdata == $past(cpu_wdata)));

  a_r3_latch_index: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_cs_n && !cpu_rnw && cpu_a0) |=>
      (psg_bdir && psg_bc1 && shadow_idx == $past(cpu_wdata[IDX_W-1:0])));

  a_r4_read_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_cs_n && cpu_rnw && !cpu_a0) |=> (cpu_rdata_oe && !psg_bdir && psg_bc1));

  a_r5_odd_read_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_cs_n && cpu_rnw && cpu_a0) |=> (!psg_bdir && !psg_bc1 && !cpu_rdata_oe));

  a_r6_deselect_idle: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_cs_n |=> (!psg_bdir && !psg_bc1 && $stable(shadow_idx)));

  a_r7_bc2_high: assert property (@(posedge clk) disable iff (!rst_n) psg_bc2);

  a_r8_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
    !(psg_wdata_oe && cpu_rdata_oe));
endmodule

bind psg_bus_adapter psg_bus_adapter_chk #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_s_n),
  .cpu_cs_n     (cpu_cs_n),
  .cpu_rnw      (cpu_rnw),
  .cpu_a0       (cpu_a0),
  .cpu_wdata    (cpu_wdata),
  .cpu_rdata_oe (cpu_rdata_oe),
  .psg_bdir     (psg_bdir),
  .psg_bc2      (psg_bc2),
  .psg_bc1      (psg_bc1),
  .psg_wdata    (psg_wdata),
  .psg_wdata_oe (psg_wdata_oe),
  .shadow_idx   (shadow_idx)
);

// File: tb/tb_psg_bus_adapter.sv
`timescale 1ns/1ps
module tb_psg_bus_adapter;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cpu_cs_n, cpu_rnw, cpu_a0;
  logic [7:0] cpu_wdata, cpu_rdata, psg_wdata, psg_rdata, shadow_data;
  logic       cpu_rdata_oe, psg_bdir, psg_bc2, psg_bc1, psg_wdata_oe;
  logic [3:0] shadow_idx;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] model [16];

  always #2 clk = ~clk;

  psg_bus_adapter dut (
    .clk(clk), .rst_n(rst_n), .cpu_cs_n(cpu_cs_n), .cpu_rnw(cpu_rnw),
    .cpu_a0(cpu_a0), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .cpu_rdata_oe(cpu_rdata_oe), .psg_bdir(psg_bdir), .psg_bc2(psg_bc2),
    .psg_bc1(psg_bc1), .psg_wdata(psg_wdata), .psg_wdata_oe(psg_wdata_oe),
    .psg_rdata(psg_rdata), .shadow_idx(shadow_idx), .shadow_data(shadow_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // One access per cycle; sample 1 ns after the edge that registers it.
  task automatic bus(input logic cs_n, input logic rnw, input logic a0, input logic [7:0] d);
    @(negedge clk);
    cpu_cs_n = cs_n; cpu_rnw = rnw; cpu_a0 = a0; cpu_wdata = d;
    @(posedge clk);
    #1;
  endtask

  task automatic code_is(input string req, input logic bdir, input logic bc1);
    chk({req, " bdir"}, psg_bdir, bdir);
    chk({req, " bc1"}, psg_bc1, bc1);
    chk("R7 bc2", psg_bc2, 1'b1);
  endtask

  task automatic t_reset;
    code_is("R1", 1'b0, 1'b0);
    chk("R1 wdata_oe", psg_wdata_oe, 1'b0);
    chk("R1 rdata_oe", cpu_rdata_oe, 1'b0);
    chk("R1 idx", shadow_idx, 4'd0);
    chk("R1 shadow", shadow_data, 8'h00);
  endtask

  task automatic t_latch;
    bus(1'b0, 1'b0, 1'b1, 8'h03);
    code_is("R3", 1'b1, 1'b1);
    chk("R3 data", psg_wdata, 8'h03);
    chk("R3 oe", psg_wdata_oe, 1'b1);
    chk("R3 idx", shadow_idx, 4'd3);
    chk("R8 no cpu drive", cpu_rdata_oe, 1'b0);
  endtask

  task automatic t_write_all;
    for (int i = 0; i < 16; i++) begin
      logic [7:0] v;
      v = 8'hA0 ^ 8'(i * 7);
      bus(1'b0, 1'b0, 1'b1, 8'(i));
      bus(1'b0, 1'b0, 1'b0, v);
      model[i] = v;
      code_is("R2", 1'b1, 1'b0);
      chk("R2 data", psg_wdata, v);
      chk("R2 oe", psg_wdata_oe, 1'b1);
      chk("R10 stored", shadow_data, v);
    end
    for (int i = 15; i >= 0; i--) begin
      bus(1'b0, 1'b0, 1'b1, 8'(i));
      chk("R10 readback", shadow_data, model[i]);
    end
  endtask

  task automatic t_read;
    psg_rdata = 8'h5C;
    bus(1'b0, 1'b1, 1'b0, 8'h00);
    code_is("R4", 1'b0, 1'b1);
    chk("R4 oe", cpu_rdata_oe, 1'b1);
    chk("R4 data", cpu_rdata, 8'h5C);
    chk("R8 psg oe", psg_wdata_oe, 1'b0);
    psg_rdata = 8'hC3;
    #0.5;
    chk("R4 pass", cpu_rdata, 8'hC3);
    bus(1'b1, 1'b1, 1'b0, 8'h00);
    chk("R11 oe", cpu_rdata_oe, 1'b0);
    chk("R11 zero", cpu_rdata, 8'h00);
  endtask

  task automatic t_odd_read;
    logic [3:0] idx0;
    idx0 = shadow_idx;
    bus(1'b0, 1'b1, 1'b1, 8'hFF);
    code_is("R5", 1'b0, 1'b0);
    chk("R5 cpu oe", cpu_rdata_oe, 1'b0);
    chk("R5 psg oe", psg_wdata_oe, 1'b0);
    chk("R5 idx", shadow_idx, idx0);
  endtask

  task automatic t_deselect;
    logic [3:0] idx0;
    idx0 = shadow_idx;
    for (int k = 0; k < 4; k++) begin
      bus(1'b1, k[1], k[0], 8'hFF);
      code_is("R6", 1'b0, 1'b0);
      chk("R6 idx", shadow_idx, idx0);
      chk("R6 data", shadow_data, model[idx0]);
      chk("R6 oe", psg_wdata_oe, 1'b0);
    end
  endtask

  task automatic t_index_mask;
    bus(1'b0, 1'b0, 1'b1, 8'hF5);
    chk("R9 idx", shadow_idx, 4'd5);
    chk("R9 data", shadow_data, model[5]);
    bus(1'b0, 1'b0, 1'b0, 8'h77);
    model[5] = 8'h77;
    bus(1'b0, 1'b0, 1'b1, 8'h25);
    chk("R9 alias", shadow_data, 8'h77);
  endtask

  initial begin
    rst_n = 1'b0;
    cpu_cs_n = 1'b1; cpu_rnw = 1'b1; cpu_a0 = 1'b0;
    cpu_wdata = 8'h00; psg_rdata = 8'h00;
    for (int i = 0; i < 16; i++) model[i] = 8'h00;
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    t_latch();
    t_write_all();
    t_read();
    t_odd_read();
    t_deselect();
    t_index_mask();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule